// File: doc/BRIEF.md
# SPI Multi-Line Chip-Select Controller

This block produces the chip-select pins of an SPI master that serves up to four peripherals. Software chooses the target with a two-bit line index and sets one polarity control that applies to every pin. With active-low polarity, every line that is not the target rests high. With active-high polarity, every such line rests low. The transfer engine supplies a busy flag. It does not generate the serial clock and it does not shift any data.

The target line has two ways to be driven. In automatic mode it takes its asserted level while the engine reports busy, and returns to its resting level when busy drops. In manual mode a level input is copied onto the target line unchanged, and polarity does not alter it. Polarity still sets the resting level of the other lines in manual mode. All pins are registered, so every input change reaches the pins one clock edge later.

Top module: `cs_select_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge with reset inactive, all four pins are high. This matches active-low polarity, automatic mode, nothing asserted.
- R2: Every line whose index differs from `sel_idx` is driven to the value of `pol_act_low`: 1 means it rests high, 0 means it rests low.
- R3: In automatic mode (`man_mode` = 0) with `xfer_busy` = 1, the target line is driven to NOT `pol_act_low`: low when active-low, high when active-high.
- R4: In automatic mode with `xfer_busy` = 0, the target line is driven to its resting level, equal to `pol_act_low`.
- R5: In manual mode (`man_mode` = 1), the target line is driven to `man_level` unchanged. Neither `xfer_busy` nor `pol_act_low` affects it.
- R6: In manual mode, lines other than the target still follow `pol_act_low` as in R2.
- R7: `sel_idx` value k (0 to 3) makes pin bit k of `cs_pins` the target. At most one pin ever differs from the resting level.
- R8: Each pin takes the value computed from the inputs sampled at the previous rising clock edge. When the index changes, the new line takes the driven level and the old line returns to its resting level on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_idx | input | 2 | Index of the target chip-select line |
| pol_act_low | input | 1 | 1: lines assert low and rest high; 0: the reverse |
| man_mode | input | 1 | 1: manual control of the target line; 0: automatic |
| man_level | input | 1 | Raw level placed on the target line in manual mode |
| xfer_busy | input | 1 | Busy flag from the transfer engine |
| cs_pins | output | 4 | Registered chip-select pins |

## Verification
The bench sweeps every combination of index, polarity, mode, manual level and busy, and predicts each pin arithmetically. This catches three kinds of fault:
- a design that applied polarity to the manual level, which would invert the pin;
- a design that let manual mode release the other lines, which would pull them low under active-low polarity;
- a decoder with a wrong bit order, which would assert the mirrored line.

Separate checks cover the remaining corner cases:
- a change of index mid-transfer, which shows whether the old line lingers or releases a cycle late;
- the reset state, which catches pins resting low while the polarity register still holds its reset value;
- the cycle just before the edge, which catches a design whose pins react combinationally.

// File: rtl/cs_sel_pkg.sv
package cs_sel_pkg;

  // Mode controls shared by the level generator and the top.
  typedef struct packed {
    logic act_low;   // 1: asserted level is low, idle level is high
    logic manual;    // 1: target line copies the raw level
    logic raw_lvl;   // raw level used in manual mode
  } cs_mode_t;

  // Resting level of any line that is not being asserted.
  function automatic logic cs_idle_of(input logic act_low);
    return act_low;
  endfunction

  // Level wanted on the target line.
  function automatic logic cs_target_level(input cs_mode_t mode, input logic busy);
    logic lvl;
    if (mode.manual) lvl = mode.raw_lvl;
    else if (busy)   lvl = ~cs_idle_of(mode.act_low);
    else             lvl = cs_idle_of(mode.act_low);
    return lvl;
  endfunction

endpackage

// File: rtl/cs_idx_decode.sv
module cs_idx_decode #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_CS-1:0] sel_oh
);

  // One-hot expansion of the line index.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
    assign sel_oh[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/cs_level_gen.sv
module cs_level_gen
  import cs_sel_pkg::*;
(
  input  cs_mode_t mode,
  input  logic     busy,
  output logic     target_lvl,
  output logic     idle_lvl
);

  always_comb begin
    target_lvl = cs_target_level(mode, busy);
    idle_lvl   = cs_idle_of(mode.act_low);
  end

endmodule

// File: rtl/cs_pin_bank.sv
module cs_pin_bank #(
  parameter int   NUM_CS    = 4,
  parameter logic RESET_LVL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] sel_oh,
  input  logic              target_lvl,
  input  logic              idle_lvl,
  output logic [NUM_CS-1:0] pins
);

  // One flop per line; the selected line takes the target level,
  // every other line its resting level, all on the same edge.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pins[g] <= RESET_LVL;
      else if (sel_oh[g]) pins[g] <= target_lvl;
      else                pins[g] <= idle_lvl;
    end
  end

endmodule

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              pol_act_low,
  input  logic              man_mode,
  input  logic              man_level,
  input  logic              xfer_busy,
  output logic [NUM_CS-1:0] cs_pins
);

  cs_mode_t          mode;
  logic [NUM_CS-1:0] sel_oh;
  logic              target_lvl;
  logic              idle_lvl;

  assign mode = '{act_low: pol_act_low, manual: man_mode, raw_lvl: man_level};

  cs_idx_decode #(.NUM_CS(NUM_CS)) u_dec (
    .idx    (sel_idx),
    .sel_oh (sel_oh)
  );

  cs_level_gen u_lvl (
    .mode       (mode),
    .busy       (xfer_busy),
    .target_lvl (target_lvl),
    .idle_lvl   (idle_lvl)
  );

  cs_pin_bank #(.NUM_CS(NUM_CS), .RESET_LVL(1'b1)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_oh     (sel_oh),
    .target_lvl (target_lvl),
    .idle_lvl   (idle_lvl),
    .pins       (cs_pins)
  );

  // Set after the first edge out of reset: from then on, $past inputs
  // are the ones that produced the current pin values.
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // End-to-end checks from ports to pins, one edge of latency (R8).
  for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
    assert_deselected_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(sel_idx != IDX_W'(g)) |-> cs_pins[g] == $past(pol_act_low));

    assert_auto_asserted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(sel_idx == IDX_W'(g) && !man_mode && xfer_busy)
      |-> cs_pins[g] != $past(pol_act_low));

    assert_auto_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(sel_idx == IDX_W'(g) && !man_mode && !xfer_busy)
      |-> cs_pins[g] == $past(pol_act_low));

    assert_manual_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(sel_idx == IDX_W'(g) && man_mode)
      |-> cs_pins[g] == $past(man_level));
  end

  // At most one line away from the resting level (R7).
  assert_single_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $countones(cs_pins ^ {NUM_CS{$past(pol_act_low)}}) <= 1);

  // Before the first loaded edge the pins hold the reset value (R1).
  assert_reset_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> cs_pins == {NUM_CS{1'b1}});

endmodule

// File: tb/test_cs_select_ctrl.sv
`timescale 1ns/1ps
module test_cs_select_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_idx = 2'd0;
  logic       pol_act_low = 1'b0;
  logic       man_mode = 1'b0;
  logic       man_level = 1'b0;
  logic       xfer_busy = 1'b0;
  logic [3:0] cs_pins;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cs_select_ctrl i_cs_select_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_idx     (sel_idx),
    .pol_act_low (pol_act_low),
    .man_mode    (man_mode),
    .man_level   (man_level),
    .xfer_busy   (xfer_busy),
    .cs_pins     (cs_pins)
  );

  // Expected pin vector computed from the requirements.
  function automatic logic [3:0] expect_pins(input int sel, input logic pol,
                                             input logic man, input logic lvl,
                                             input logic busy);
    logic [3:0] v;
    for (int k = 0; k < 4; k++) begin
      if (k != sel)  v[k] = pol;              // R2 / R6
      else if (man)  v[k] = lvl;              // R5
      else           v[k] = busy ? !pol : pol; // R3 / R4
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: cs_pins=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input int sel, input logic pol, input logic man,
                       input logic lvl, input logic busy);
    sel_idx     = 2'(sel);
    pol_act_low = pol;
    man_mode    = man;
    man_level   = lvl;
    xfer_busy   = busy;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset value, even with active-high polarity requested
    apply(1, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 during reset", cs_pins, 4'hF);
    rst_n = 1'b1;
    #1;
    check("R1 after release before edge", cs_pins, 4'hF);
    @(negedge clk);

    // Full sweep: R2..R7 with the one-edge latency of R8
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int l = 0; l < 2; l++)
          for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++) begin
              string tag;
              apply(s, 1'(p), 1'(m), 1'(l), 1'(b));
              @(negedge clk);
              if (m != 0)      tag = $sformatf("R5/R6/R7 sel=%0d pol=%0d lvl=%0d busy=%0d", s, p, l, b);
              else if (b != 0) tag = $sformatf("R3/R2/R7 sel=%0d pol=%0d", s, p);
              else             tag = $sformatf("R4/R2 sel=%0d pol=%0d", s, p);
              check(tag, cs_pins, expect_pins(s, 1'(p), 1'(m), 1'(l), 1'(b)));
            end

    // R8: index change mid-transfer, latency of exactly one edge
    apply(0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 start on line 0", cs_pins, 4'b1110);
    apply(2, 1'b1, 1'b0, 1'b0, 1'b1);
    #1;
    check("R8 before edge old value held", cs_pins, 4'b1110);
    @(negedge clk);
    check("R8 moved to line 2, line 0 released", cs_pins, 4'b1011);
    apply(3, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 polarity and index change together", cs_pins, 4'b1000);

    // R5: manual level passes through unchanged while busy toggles
    apply(1, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R5 manual high under active-low", cs_pins, 4'b1111);
    xfer_busy = 1'b0;
    man_level = 1'b0;
    @(negedge clk);
    check("R5 manual low, busy ignored", cs_pins, 4'b1101);

    // R1: reset reasserted returns all pins high
    rst_n = 1'b0;
    #1;
    check("R1 asynchronous reset", cs_pins, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule